// File: doc/BRIEF.md
# Overhead Defect Persistence Monitor

The monitor takes three overhead bytes once per frame: the line protection byte (K2), the path status byte (G1) and the path signal label (C2). A single-cycle frame strobe marks the cycle in which these bytes are valid. Each of six defect conditions has its own persistence filter. A defect becomes active only after its code has been seen in a run of consecutive frames. It becomes inactive only after the same number of consecutive frames without the code. A frame that breaks a run restarts that run from zero.

The block reports six status bits: line alarm indication, line far-end receive failure, path far-end receive failure, path remote defect, path unequipped and payload label mismatch. The frame counts for the two line defects and the path remote defect can be programmed through a small write-only register port. A path alarm indication input comes from the pointer processor and clears the path remote defect at once. Every change of a status bit produces a one-cycle interrupt pulse.

Bit numbering follows transmission order: bit 1 is the most significant bit (bit 7 in the vectors) and bit 8 is bit 0.

Top module: `ohd_defect_mon`

## Requirements
- R1: After reset, all status bits and the interrupt are 0. The persistence counts are 5 for the line alarm, 5 for the line receive failure and 10 for the path remote defect.
- R2: status_o[0] (line alarm) sets after N consecutive frames with k2_i[2:0]==3'b111. It clears after N consecutive frames with any other value. N is the register at address 0.
- R3: status_o[1] (line receive failure) sets after N consecutive frames with k2_i[2:0]==3'b110. It clears after N consecutive frames with any other value. N is the register at address 1.
- R4: status_o[2] (path receive failure) shows, after each frame, whether that frame had g1_i[7:4]==4'b1001.
- R5: status_o[3] (path remote defect) sets after N consecutive frames in which g1_i[3] or g1_i[2] is 1. It clears after N consecutive frames in which both bits are 0. N is the register at address 2.
- R6: pais_i high at a clock edge clears status_o[3] and its run at that edge. While pais_i stays high, status_o[3] stays 0.
- R7: status_o[4] (unequipped) sets after 5 consecutive frames with c2_i==8'h00. It clears after 5 consecutive frames with any other value.
- R8: status_o[5] (label mismatch) sets after 5 consecutive frames with c2_i not in {8'h00, 8'h01, 8'h13}. It clears after 5 consecutive frames with a value in that set. status_o[4] and status_o[5] are never both 1.
- R9: A frame that breaks a run restarts that defect's count, so a full run of N frames is needed afterwards.
- R10: A write (cfg_we_i high) stores cfg_wdata_i in the register selected by cfg_addr_i: 0 line alarm, 1 line receive failure, 2 path remote defect. The new value applies from the next frame strobe. A stored 0 acts as 1. Address 3 is ignored.
- R11: irq_o is high for exactly the cycles in which status_o differs from its value one cycle earlier.
- R12: Overhead bytes in cycles without frame_i have no effect on any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Strobe: overhead bytes are valid this cycle |
| k2_i | input | 8 | Line protection byte |
| g1_i | input | 8 | Path status byte |
| c2_i | input | 8 | Path signal label byte |
| pais_i | input | 1 | Path alarm indication from the pointer processor |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | 4 | Persistence count to write |
| status_o | output | 6 | Defect status bits |
| irq_o | output | 1 | One-cycle pulse on any status change |

## Verification
A wrong run counter shows up as a status bit that changes one frame early or one frame late. The bench therefore samples every filter at frame N-1 and at frame N, both when setting and when clearing. A counter that is not cleared when a run breaks sets the defect early in the broken-run test, within the first frames of the second run. A wrong threshold register or a wrong address decode changes the frame on which the status first changes after a write. A stuck or stretched interrupt differs from the status edge in the same cycle.

// File: rtl/ohd_pkg.sv
package ohd_pkg;
  localparam int NDEF    = 6;
  localparam int D_LAIS  = 0;
  localparam int D_LFERF = 1;
  localparam int D_PFERF = 2;
  localparam int D_PRDI  = 3;
  localparam int D_UNEQ  = 4;
  localparam int D_PLM   = 5;

  function automatic logic label_known(input logic [7:0] c2);
    return (c2 == 8'h00) || (c2 == 8'h01) || (c2 == 8'h13);
  endfunction
endpackage

// File: rtl/ohd_persist_filter.sv
module ohd_persist_filter #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic          cond_i,
  input  logic [CW-1:0] thr_i,
  input  logic          kill_i,
  output logic          state_o,
  output logic          change_o
);
  logic          state_q, state_d;
  logic [CW-1:0] run_q, run_d;
  logic [CW:0]   run_inc;

  assign run_inc = {1'b0, run_q} + 1'b1;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    if (kill_i) begin
      state_d = 1'b0;
      run_d   = '0;
    end else if (strobe_i) begin
      if (cond_i != state_q) begin
        if (run_inc >= {1'b0, thr_i}) begin
          state_d = cond_i;
          run_d   = '0;
        end else begin
          run_d = run_inc[CW-1:0];
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  assign state_o  = state_q;
  assign change_o = state_d ^ state_q;
endmodule

// File: rtl/ohd_cfg_regs.sv
module ohd_cfg_regs #(
  parameter int CW        = 4,
  parameter int LAIS_DEF  = 5,
  parameter int LFERF_DEF = 5,
  parameter int PRDI_DEF  = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] thr_lais_o,
  output logic [CW-1:0] thr_lferf_o,
  output logic [CW-1:0] thr_prdi_o
);
  logic [CW-1:0] lais_q, lferf_q, prdi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lais_q  <= CW'(LAIS_DEF);
      lferf_q <= CW'(LFERF_DEF);
      prdi_q  <= CW'(PRDI_DEF);
    end else if (we_i) begin
      case (addr_i)
        2'd0:    lais_q  <= wdata_i;
        2'd1:    lferf_q <= wdata_i;
        2'd2:    prdi_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // zero count behaves as one frame
  assign thr_lais_o  = (lais_q  == '0) ? CW'(1) : lais_q;
  assign thr_lferf_o = (lferf_q == '0) ? CW'(1) : lferf_q;
  assign thr_prdi_o  = (prdi_q  == '0) ? CW'(1) : prdi_q;
endmodule

// File: rtl/ohd_defect_mon.sv
module ohd_defect_mon
  import ohd_pkg::*;
#(
  parameter int CW         = 4,
  parameter int LAIS_DEF   = 5,
  parameter int LFERF_DEF  = 5,
  parameter int PRDI_DEF   = 10,
  parameter int C2_PERSIST = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_i,
  input  logic [7:0]      k2_i,
  input  logic [7:0]      g1_i,
  input  logic [7:0]      c2_i,
  input  logic            pais_i,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_addr_i,
  input  logic [CW-1:0]   cfg_wdata_i,
  output logic [NDEF-1:0] status_o,
  output logic            irq_o
);
  logic [NDEF-1:0] cond, change;
  logic [CW-1:0]   thr [NDEF];
  logic [CW-1:0]   thr_lais, thr_lferf, thr_prdi;
  logic            irq_q;

  ohd_cfg_regs #(
    .CW(CW), .LAIS_DEF(LAIS_DEF), .LFERF_DEF(LFERF_DEF), .PRDI_DEF(PRDI_DEF)
  ) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .thr_lais_o (thr_lais),
    .thr_lferf_o(thr_lferf),
    .thr_prdi_o (thr_prdi)
  );

  // bit 1 of a byte is the MSB
  always_comb begin
    cond[D_LAIS]  = (k2_i[2:0] == 3'b111);
    cond[D_LFERF] = (k2_i[2:0] == 3'b110);
    cond[D_PFERF] = (g1_i[7:4] == 4'b1001);
    cond[D_PRDI]  = g1_i[3] | g1_i[2];
    cond[D_UNEQ]  = (c2_i == 8'h00);
    cond[D_PLM]   = !label_known(c2_i);
    thr[D_LAIS]   = thr_lais;
    thr[D_LFERF]  = thr_lferf;
    thr[D_PFERF]  = CW'(1);
    thr[D_PRDI]   = thr_prdi;
    thr[D_UNEQ]   = CW'(C2_PERSIST);
    thr[D_PLM]    = CW'(C2_PERSIST);
  end

  for (genvar i = 0; i < NDEF; i++) begin : g_flt
    logic kill;
    if (i == D_PRDI) begin : g_kill
      assign kill = pais_i;
    end else begin : g_nokill
      assign kill = 1'b0;
    end
    ohd_persist_filter #(.CW(CW)) i_flt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strobe_i(frame_i),
      .cond_i  (cond[i]),
      .thr_i   (thr[i]),
      .kill_i  (kill),
      .state_o (status_o[i]),
      .change_o(change[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |change;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ohd_defect_mon_chk.sv
module ohd_defect_mon_chk
  import ohd_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frame_i,
  input logic [7:0]      g1_i,
  input logic            pais_i,
  input logic [NDEF-1:0] status_o,
  input logic            irq_o
);
  localparam logic [NDEF-1:0] KEEP = ~(NDEF'(1) << D_PRDI);

  p_irq_on_change_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o != $past(status_o)));

  p_pferf_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_i) |-> (status_o[D_PFERF] == ($past(g1_i[7:4]) == 4'b1001)));

  p_pais_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pais_i) |-> !status_o[D_PRDI]);

  p_hold_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_i) |-> ((status_o & KEEP) == ($past(status_o) & KEEP)));

  p_c2_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[D_UNEQ] && status_o[D_PLM]));
endmodule

bind ohd_defect_mon ohd_defect_mon_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .frame_i (frame_i),
  .g1_i    (g1_i),
  .pais_i  (pais_i),
  .status_o(status_o),
  .irq_o   (irq_o)
);

// File: tb/test_ohd_defect_mon.sv
`timescale 1ns/1ps
module test_ohd_defect_mon;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic [7:0] k2_i = 8'h00, g1_i = 8'h00, c2_i = 8'h01;
  logic       pais_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_addr_i = 2'd0;
  logic [3:0] cfg_wdata_i = 4'd0;
  logic [5:0] status_o;
  logic       irq_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  ohd_defect_mon i_ohd_defect_mon (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input int idx, input bit exp, input string req);
    chk(status_o[idx] == exp, req, int'(status_o[idx]), int'(exp));
  endtask

  // one frame, then an idle cycle; checks the interrupt against the status edge
  task automatic frame(input logic [7:0] k2, input logic [7:0] g1, input logic [7:0] c2);
    logic [5:0] prev;
    @(negedge clk_i);
    prev = status_o;
    frame_i = 1'b1; k2_i = k2; g1_i = g1; c2_i = c2;
    @(negedge clk_i);
    frame_i = 1'b0; k2_i = 8'h00; g1_i = 8'h00; c2_i = 8'h01;
    chk(irq_o == (status_o != prev), "R11", int'(irq_o), int'(status_o != prev));
  endtask

  task automatic frames(input int n, input logic [7:0] k2, input logic [7:0] g1, input logic [7:0] c2);
    for (int i = 0; i < n; i++) frame(k2, g1, c2);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(status_o == 6'd0, "R1", int'(status_o), 0);
    chk(irq_o == 1'b0, "R1", int'(irq_o), 0);
  endtask

  task automatic t_lais; // R2, default 5
    frames(4, 8'h07, 8'h00, 8'h01); chk_bit(0, 1'b0, "R2 set early");
    frame(8'h07, 8'h00, 8'h01);     chk_bit(0, 1'b1, "R2 set");
    chk(irq_o == 1'b1, "R11 pulse", int'(irq_o), 1);
    @(negedge clk_i); chk(irq_o == 1'b0, "R11 width", int'(irq_o), 0);
    frames(4, 8'h05, 8'h00, 8'h01); chk_bit(0, 1'b1, "R2 clear early");
    frame(8'h05, 8'h00, 8'h01);     chk_bit(0, 1'b0, "R2 clear");
  endtask

  task automatic t_lferf_break; // R3, R9
    frames(3, 8'h06, 8'h00, 8'h01);
    frame(8'h07, 8'h00, 8'h01);
    frames(4, 8'h06, 8'h00, 8'h01); chk_bit(1, 1'b0, "R9 restart");
    frame(8'h06, 8'h00, 8'h01);     chk_bit(1, 1'b1, "R3 set");
    chk_bit(0, 1'b0, "R2 other code");
    frames(4, 8'h00, 8'h00, 8'h01); chk_bit(1, 1'b1, "R3 clear early");
    frame(8'h00, 8'h00, 8'h01);     chk_bit(1, 1'b0, "R3 clear");
  endtask

  task automatic t_pferf; // R4
    frame(8'h00, 8'h90, 8'h01); chk_bit(2, 1'b1, "R4 set");
    frame(8'h00, 8'h80, 8'h01); chk_bit(2, 1'b0, "R4 clear");
  endtask

  task automatic t_prdi; // R5, R6
    frames(9, 8'h00, 8'h08, 8'h01); chk_bit(3, 1'b0, "R5 set early");
    frame(8'h00, 8'h04, 8'h01);     chk_bit(3, 1'b1, "R5 set");
    @(negedge clk_i); pais_i = 1'b1;
    @(negedge clk_i); chk_bit(3, 1'b0, "R6 clear");
    chk(irq_o == 1'b1, "R11 pais", int'(irq_o), 1);
    frames(10, 8'h00, 8'h0C, 8'h01); chk_bit(3, 1'b0, "R6 hold");
    pais_i = 1'b0;
    frames(9, 8'h00, 8'h08, 8'h01); chk_bit(3, 1'b0, "R6 run reset");
    frames(10, 8'h00, 8'h00, 8'h01); chk_bit(3, 1'b0, "R5 stays clear");
  endtask

  task automatic t_c2; // R7, R8
    frames(4, 8'h00, 8'h00, 8'h00); chk_bit(4, 1'b0, "R7 set early");
    frame(8'h00, 8'h00, 8'h00);     chk_bit(4, 1'b1, "R7 set");
    frames(4, 8'h00, 8'h00, 8'h55); chk_bit(5, 1'b0, "R8 set early");
    frame(8'h00, 8'h00, 8'h55);
    chk_bit(4, 1'b0, "R7 clear"); chk_bit(5, 1'b1, "R8 set");
    frames(4, 8'h00, 8'h00, 8'h13); chk_bit(5, 1'b1, "R8 clear early");
    frame(8'h00, 8'h00, 8'h13);     chk_bit(5, 1'b0, "R8 clear");
  endtask

  task automatic t_cfg; // R10
    wr(2'd0, 4'd2);
    frame(8'h07, 8'h00, 8'h01); chk_bit(0, 1'b0, "R10 lais 1st");
    frame(8'h07, 8'h00, 8'h01); chk_bit(0, 1'b1, "R10 lais 2nd");
    frames(2, 8'h00, 8'h00, 8'h01); chk_bit(0, 1'b0, "R10 lais clear");
    wr(2'd1, 4'd0);
    frame(8'h06, 8'h00, 8'h01); chk_bit(1, 1'b1, "R10 zero as one");
    frame(8'h00, 8'h00, 8'h01); chk_bit(1, 1'b0, "R10 zero clear");
    wr(2'd3, 4'd1);
    frames(9, 8'h00, 8'h08, 8'h01); chk_bit(3, 1'b0, "R10 addr3 ignored");
    frame(8'h00, 8'h08, 8'h01);     chk_bit(3, 1'b1, "R10 prdi default");
    wr(2'd2, 4'd3);
    frames(2, 8'h00, 8'h00, 8'h01); chk_bit(3, 1'b1, "R10 prdi early");
    frame(8'h00, 8'h00, 8'h01);     chk_bit(3, 1'b0, "R10 prdi 3");
  endtask

  task automatic t_idle; // R12
    @(negedge clk_i);
    k2_i = 8'h07; g1_i = 8'h9C; c2_i = 8'h00;
    repeat (40) @(negedge clk_i);
    chk(status_o == 6'd0, "R12 no strobe", int'(status_o), 0);
    chk(irq_o == 1'b0, "R12 no irq", int'(irq_o), 0);
    k2_i = 8'h00; g1_i = 8'h00; c2_i = 8'h01;
  endtask

  initial begin
    #200_000ns;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_lais();
    t_lferf_break();
    t_pferf();
    t_prdi();
    t_c2();
    t_cfg();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule